// File: doc/BRIEF.md
# Converter Result Register Bank with Coherent Two-Byte Readout

This block sits between an analog-to-digital converter that produces 10-bit results and an 8-bit register read bus. Every result the converter reports is formatted into a 16-bit word and kept as a low data byte and a high data byte. A control bit chooses between right-adjusted and left-adjusted formatting. In left-adjusted form the high byte alone carries the eight most significant result bits.

Software reads the low byte first and the high byte second. The low-byte read freezes both data bytes, so the two halves always belong to the same conversion. The high-byte read releases them. A conversion that finishes while the bytes are frozen is thrown away, but it still raises the conversion-complete flag. That flag drives an interrupt request through an enable bit. A converter enable bit gates result capture. It also gates the hand-over of staged channel and reference selections to the converter.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, all four registers read zero, the lock is released, `irq` is low and the applied channel and reference outputs are zero.
- R2: With the adjust bit (control bit 1) clear, a result v is stored as low byte v[7:0] (address 0) and high byte {000000, v[9:8]} (address 1).
- R3: With the adjust bit set, a result v is stored as high byte v[9:2] and low byte {v[1:0], 000000}.
- R4: The adjust bit is sampled when a result is written into the data bytes. Changing it later does not reformat a stored value.
- R5: A read of address 0 locks the data bytes. While the lock is held, a result committing in the same cycle as that read, or at any later point until the lock is released, leaves both bytes unchanged.
- R6: A read of address 1 releases the lock. The next result after the release is stored.
- R7: A strobe on `conv_done` captured with the enable set commits one cycle later. Data and the flag (control bit 3) are visible after the following clock edge. The flag is set on every commit, including a commit that the lock discards.
- R8: Writing control address 2 with bit 3 set clears the flag. Writing bit 3 as zero leaves the flag alone. A commit in the same cycle wins over the clear.
- R9: `irq` is high exactly when the flag and the interrupt-enable bit (control bit 2) are both set.
- R10: With the enable bit (control bit 0) clear, strobes are ignored. A strobe in the same cycle as a write that clears the enable is dropped, and it sets neither data nor flag.
- R11: Writes to address 3 stage a channel (bits 3:0) and a reference (bits 5:4). The applied outputs copy the staged value one cycle later, and only while the enable is set. Otherwise they hold.
- R12: Reads of addresses 2 and 3 and bus writes to addresses 0 and 1 change neither the lock nor the data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| conv_value | input | 10 | Result of the finished conversion |
| bus_addr | input | 2 | Register address: 0 low data, 1 high data, 2 control, 3 selection |
| bus_rd | input | 1 | Read strobe for the addressed register |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Content of the addressed register |
| irq | output | 1 | Conversion-complete interrupt request |
| applied_chan | output | 4 | Channel selection handed to the converter |
| applied_ref | output | 2 | Reference selection handed to the converter |

## Verification
The assertions assume that every read and write strobe lasts exactly one cycle. They also assume that the bus never reads and writes in the same cycle, and that `conv_done` is a single-cycle pulse whose value is valid with it. The stimulus keeps to these limits by construction: it drives each cycle from one task that raises at most one of the two bus strobes, and it treats a strobe as valid for that cycle only. Results arrive at random while the lock is held and while it is being released. They also arrive in the same cycle as lock-taking reads and together with enable changes, so the discard and drop paths are exercised many times.

// File: rtl/adcrl_pkg.sv
package adcrl_pkg;
   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] ADR_LO   = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_HI   = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;
   localparam logic [ADDR_W-1:0] ADR_SEL  = 2'd3;
   localparam int CB_EN   = 0;
   localparam int CB_ADJ  = 1;
   localparam int CB_IE   = 2;
   localparam int CB_FLAG = 3;

   typedef struct packed {
      logic rd_lo;
      logic rd_hi;
      logic wr_ctrl;
      logic wr_sel;
   } bus_dec_t;
endpackage

// File: rtl/adcrl_capture.sv
module adcrl_capture #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_next,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_value,
   output logic             pend_o,
   output logic [RES_W-1:0] value_o
);
   logic             pend_q;
   logic [RES_W-1:0] value_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         value_q <= '0;
      end else begin
         pend_q <= conv_done & en_next;
         if (conv_done & en_next) value_q <= conv_value;
      end
   end

   assign pend_o  = pend_q;
   assign value_o = value_q;
endmodule

// File: rtl/adcrl_format.sv
module adcrl_format #(
   parameter int RES_W = 10,
   parameter int BUS_W = 8
) (
   input  logic               left,
   input  logic [RES_W-1:0]   value,
   output logic [2*BUS_W-1:0] word
);
   localparam int PAD = 2*BUS_W - RES_W;
   logic [2*BUS_W-1:0] right_w;
   logic [2*BUS_W-1:0] left_w;

   generate
      if (PAD == 0) begin : g_full
         assign right_w = value;
         assign left_w  = value;
      end else begin : g_pad
         assign right_w = {{PAD{1'b0}}, value};
         assign left_w  = {value, {PAD{1'b0}}};
      end
   endgenerate

   assign word = left ? left_w : right_w;
endmodule

// File: rtl/adcrl_store.sv
module adcrl_store #(
   parameter int BUS_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [2*BUS_W-1:0] word,
   input  logic               rd_lo,
   input  logic               rd_hi,
   output logic [2*BUS_W-1:0] data_o,
   output logic               lock_o
);
   logic [2*BUS_W-1:0] data_q;
   logic               lock_q;
   logic               blocked;

   assign blocked = lock_q | rd_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         lock_q <= 1'b0;
      end else begin
         if (commit && !blocked) data_q <= word;
         if (rd_lo)      lock_q <= 1'b1;
         else if (rd_hi) lock_q <= 1'b0;
      end
   end

   assign data_o = data_q;
   assign lock_o = lock_q;
endmodule

// File: rtl/adcrl_ctrl.sv
module adcrl_ctrl #(
   parameter int CHAN_W = 4,
   parameter int REF_W  = 2,
   parameter int BUS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_sel,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              commit,
   output logic              en_o,
   output logic              en_next_o,
   output logic              adj_o,
   output logic              ie_o,
   output logic              flag_o,
   output logic [CHAN_W-1:0] stage_chan_o,
   output logic [REF_W-1:0]  stage_ref_o,
   output logic [CHAN_W-1:0] chan_o,
   output logic [REF_W-1:0]  ref_o
);
   import adcrl_pkg::*;
   logic              en_q, adj_q, ie_q, flag_q;
   logic [CHAN_W-1:0] s_chan_q, a_chan_q;
   logic [REF_W-1:0]  s_ref_q, a_ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         adj_q  <= 1'b0;
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q  <= wdata[CB_EN];
            adj_q <= wdata[CB_ADJ];
            ie_q  <= wdata[CB_IE];
         end
         if (commit)                         flag_q <= 1'b1;
         else if (wr_ctrl && wdata[CB_FLAG]) flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_chan_q <= '0;
         s_ref_q  <= '0;
         a_chan_q <= '0;
         a_ref_q  <= '0;
      end else begin
         if (wr_sel) begin
            s_chan_q <= wdata[CHAN_W-1:0];
            s_ref_q  <= wdata[CHAN_W +: REF_W];
         end
         if (en_q) begin
            a_chan_q <= s_chan_q;
            a_ref_q  <= s_ref_q;
         end
      end
   end

   assign en_o         = en_q;
   assign en_next_o    = wr_ctrl ? wdata[CB_EN] : en_q;
   assign adj_o        = adj_q;
   assign ie_o         = ie_q;
   assign flag_o       = flag_q;
   assign stage_chan_o = s_chan_q;
   assign stage_ref_o  = s_ref_q;
   assign chan_o       = a_chan_q;
   assign ref_o        = a_ref_q;
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
   parameter int RES_W  = 10,
   parameter int BUS_W  = 8,
   parameter int CHAN_W = 4,
   parameter int REF_W  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        conv_done,
   input  logic [RES_W-1:0]            conv_value,
   input  logic [adcrl_pkg::ADDR_W-1:0] bus_addr,
   input  logic                        bus_rd,
   input  logic                        bus_wr,
   input  logic [BUS_W-1:0]            bus_wdata,
   output logic [BUS_W-1:0]            bus_rdata,
   output logic                        irq,
   output logic [CHAN_W-1:0]           applied_chan,
   output logic [REF_W-1:0]            applied_ref
);
   import adcrl_pkg::*;
   localparam int WORD_W = 2*BUS_W;
   localparam int SEL_W  = CHAN_W + REF_W;

   generate
      if (RES_W <= BUS_W || RES_W > WORD_W) begin : g_bad_res
         $error("result width must exceed one bus byte and fit in two");
      end
      if (SEL_W > BUS_W) begin : g_bad_sel
         $error("channel and reference fields must fit one bus byte");
      end
      if (BUS_W < 4) begin : g_bad_bus
         $error("control register needs at least four bits");
      end
   endgenerate

   bus_dec_t          dec;
   logic              pend, en, en_next, adj, ie, flag, lock, commit;
   logic [RES_W-1:0]  pend_val;
   logic [WORD_W-1:0] fmt_word, data_word;
   logic [CHAN_W-1:0] stage_chan;
   logic [REF_W-1:0]  stage_ref;

   always_comb begin
      dec.rd_lo   = bus_rd && (bus_addr == ADR_LO);
      dec.rd_hi   = bus_rd && (bus_addr == ADR_HI);
      dec.wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
      dec.wr_sel  = bus_wr && (bus_addr == ADR_SEL);
   end

   assign commit = pend & en;

   adcrl_capture #(.RES_W(RES_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .en_next(en_next),
      .conv_done(conv_done), .conv_value(conv_value),
      .pend_o(pend), .value_o(pend_val)
   );

   adcrl_format #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
      .left(adj), .value(pend_val), .word(fmt_word)
   );

   adcrl_store #(.BUS_W(BUS_W)) u_store (
      .clk(clk), .rst_n(rst_n), .commit(commit), .word(fmt_word),
      .rd_lo(dec.rd_lo), .rd_hi(dec.rd_hi),
      .data_o(data_word), .lock_o(lock)
   );

   adcrl_ctrl #(.CHAN_W(CHAN_W), .REF_W(REF_W), .BUS_W(BUS_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(dec.wr_ctrl), .wr_sel(dec.wr_sel),
      .wdata(bus_wdata), .commit(commit),
      .en_o(en), .en_next_o(en_next), .adj_o(adj), .ie_o(ie), .flag_o(flag),
      .stage_chan_o(stage_chan), .stage_ref_o(stage_ref),
      .chan_o(applied_chan), .ref_o(applied_ref)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_LO:   bus_rdata = data_word[BUS_W-1:0];
         ADR_HI:   bus_rdata = data_word[WORD_W-1:BUS_W];
         ADR_CTRL: begin
            bus_rdata[CB_EN]   = en;
            bus_rdata[CB_ADJ]  = adj;
            bus_rdata[CB_IE]   = ie;
            bus_rdata[CB_FLAG] = flag;
         end
         default:  bus_rdata[SEL_W-1:0] = {stage_ref, stage_chan};
      endcase
   end

   assign irq = flag & ie;
endmodule

// File: rtl/adcrl_checker.sv
module adcrl_checker #(
   parameter int WORD_W = 16,
   parameter int CHAN_W = 4,
   parameter int REF_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [1:0]        bus_addr,
   input logic              wdata_flag,
   input logic              pend,
   input logic              en,
   input logic              flag,
   input logic              lock,
   input logic [WORD_W-1:0] data_word,
   input logic [CHAN_W-1:0] applied_chan,
   input logic [REF_W-1:0]  applied_ref
);
   a_r5_frozen_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !(bus_rd && bus_addr == 2'd1)) |=> ($stable(data_word) && lock));

   a_r6_high_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd1) |=> !lock);

   a_r7_commit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && en) |=> flag);

   a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2 && wdata_flag && !(pend && en)) |=> !flag);

   a_r10_disabled_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(data_word));

   a_r11_disabled_holds_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(applied_chan) && $stable(applied_ref)));

   a_r12_other_access_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock && !(bus_rd && bus_addr == 2'd0)) |=> !lock);
endmodule

bind adc_result_regs adcrl_checker #(
   .WORD_W(2*BUS_W), .CHAN_W(CHAN_W), .REF_W(REF_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .wdata_flag(bus_wdata[3]), .pend(pend), .en(en),
   .flag(flag), .lock(lock), .data_word(data_word),
   .applied_chan(applied_chan), .applied_ref(applied_ref)
);

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_done = 1'b0;
   logic [9:0] conv_value = '0;
   logic [1:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;
   logic [3:0] applied_chan;
   logic [1:0] applied_ref;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   adc_result_regs uut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq),
      .applied_chan(applied_chan), .applied_ref(applied_ref)
   );

   // expected-state model built from the requirements
   logic       m_pend, m_lock, m_en, m_adj, m_ie, m_flag;
   logic [9:0] m_val;
   logic [7:0] m_lo, m_hi;
   logic [3:0] m_schan, m_chan;
   logic [1:0] m_sref, m_ref;

   function automatic logic [15:0] fmt(input logic [9:0] v, input logic left);
      return left ? {v, 6'b0} : {6'b0, v};
   endfunction

   function automatic logic [7:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0: return m_lo;
         2'd1: return m_hi;
         2'd2: return {4'b0, m_flag, m_ie, m_adj, m_en};
         default: return {2'b0, m_sref, m_schan};
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend <= 0; m_lock <= 0; m_en <= 0; m_adj <= 0; m_ie <= 0; m_flag <= 0;
         m_val <= 0; m_lo <= 0; m_hi <= 0;
         m_schan <= 0; m_sref <= 0; m_chan <= 0; m_ref <= 0;
      end else begin
         logic commit, rlo, rhi, wctl, wsel, en_nx;
         rlo   = bus_rd && bus_addr == 2'd0;
         rhi   = bus_rd && bus_addr == 2'd1;
         wctl  = bus_wr && bus_addr == 2'd2;
         wsel  = bus_wr && bus_addr == 2'd3;
         en_nx = wctl ? bus_wdata[0] : m_en;
         commit = m_pend && m_en;
         if (commit && !(m_lock || rlo)) {m_hi, m_lo} <= fmt(m_val, m_adj);
         if (rlo) m_lock <= 1; else if (rhi) m_lock <= 0;
         if (commit) m_flag <= 1; else if (wctl && bus_wdata[3]) m_flag <= 0;
         if (wctl) begin m_en <= bus_wdata[0]; m_adj <= bus_wdata[1]; m_ie <= bus_wdata[2]; end
         m_pend <= conv_done && en_nx;
         if (conv_done && en_nx) m_val <= conv_value;
         if (wsel) begin m_schan <= bus_wdata[3:0]; m_sref <= bus_wdata[5:4]; end
         if (m_en) begin m_chan <= m_schan; m_ref <= m_sref; end
      end
   end

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic d, input logic [9:0] v, input logic r, input logic w,
                      input logic [1:0] a, input logic [7:0] wd, input string tag);
      @(negedge clk);
      conv_done = d; conv_value = v; bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = wd;
      #1;
      if (r) chk(bus_rdata, exp_read(a), tag);
      chk({7'b0, irq}, {7'b0, m_flag & m_ie}, "R9");
      chk({2'b0, applied_ref, applied_chan}, {2'b0, m_ref, m_chan}, "R11");
   endtask

   task automatic idle();
      cyc(0, '0, 0, 0, 2'd0, '0, "idle");
   endtask

   task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
      cyc(0, '0, 1, 0, a, '0, tag);
      chk(bus_rdata, e, tag);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cyc(0, '0, 0, 1, a, d, "wr");
   endtask

   task automatic conv(input logic [9:0] v);
      cyc(1, v, 0, 0, 2'd0, '0, "conv");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      rd_exp(2'd0, 8'h00, "R1"); rd_exp(2'd1, 8'h00, "R1");
      rd_exp(2'd2, 8'h00, "R1"); rd_exp(2'd3, 8'h00, "R1");
      chk({7'b0, irq}, 8'h00, "R1");
      // R2 right-adjusted
      wr(2'd2, 8'h01); conv(10'h2A5); idle(); idle();
      rd_exp(2'd0, 8'hA5, "R2"); rd_exp(2'd1, 8'h02, "R2");
      rd_exp(2'd2, 8'h09, "R7");
      wr(2'd2, 8'h09); rd_exp(2'd2, 8'h01, "R8");
      // R5 lock discards, flag still set
      rd_exp(2'd0, 8'hA5, "R5"); conv(10'h155); idle(); idle();
      rd_exp(2'd2, 8'h09, "R7"); rd_exp(2'd1, 8'h02, "R5");
      // R6 release then store
      conv(10'h155); idle(); idle();
      rd_exp(2'd0, 8'h55, "R6"); rd_exp(2'd1, 8'h01, "R6");
      // R5 commit in the same cycle as the low read
      conv(10'h0F0); rd_exp(2'd0, 8'h55, "R5"); idle();
      rd_exp(2'd1, 8'h01, "R5");
      // R12 control and selection access leaves lock alone
      rd_exp(2'd2, 8'h09, "R12"); rd_exp(2'd3, 8'h00, "R12");
      wr(2'd0, 8'hEE); wr(2'd1, 8'hEE);
      conv(10'h3C3); idle(); idle();
      rd_exp(2'd1, 8'h03, "R12"); rd_exp(2'd0, 8'hC3, "R12"); rd_exp(2'd1, 8'h03, "R12");
      // R3 left-adjusted
      wr(2'd2, 8'h03); conv(10'h2D7); idle(); idle();
      rd_exp(2'd1, 8'hB5, "R3"); rd_exp(2'd0, 8'hC0, "R3"); rd_exp(2'd1, 8'hB5, "R3");
      // R4 no reformat
      wr(2'd2, 8'h01);
      rd_exp(2'd1, 8'hB5, "R4"); rd_exp(2'd0, 8'hC0, "R4"); rd_exp(2'd1, 8'hB5, "R4");
      // R9 interrupt request
      wr(2'd2, 8'h05); idle(); chk({7'b0, irq}, 8'h01, "R9");
      wr(2'd2, 8'h0D); idle(); chk({7'b0, irq}, 8'h00, "R9");
      // R8 commit wins over clear
      conv(10'h001); wr(2'd2, 8'h09); idle(); rd_exp(2'd2, 8'h09, "R8");
      rd_exp(2'd0, 8'h01, "R8"); rd_exp(2'd1, 8'h00, "R8");
      wr(2'd2, 8'h09);
      // R10 disabled and same-cycle drop
      wr(2'd2, 8'h00); conv(10'h111); idle(); idle();
      rd_exp(2'd2, 8'h00, "R10"); rd_exp(2'd0, 8'h01, "R10"); rd_exp(2'd1, 8'h00, "R10");
      wr(2'd2, 8'h01);
      cyc(1, 10'h222, 0, 1, 2'd2, 8'h00, "R10"); idle(); idle();
      rd_exp(2'd2, 8'h00, "R10"); rd_exp(2'd0, 8'h01, "R10"); rd_exp(2'd1, 8'h00, "R10");
      // R11 selection staging
      wr(2'd3, 8'h2B); idle(); idle();
      chk({2'b0, applied_ref, applied_chan}, 8'h00, "R11");
      rd_exp(2'd3, 8'h2B, "R11");
      wr(2'd2, 8'h01); idle(); idle();
      chk({2'b0, applied_ref, applied_chan}, 8'h2B, "R11");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic d, r, w;
         logic [1:0] a;
         logic [7:0] wd;
         logic [9:0] v;
         string tag;
         d  = ($urandom % 4) == 0;
         v  = 10'($urandom);
         r  = ($urandom % 2) == 0;
         w  = !r && (($urandom % 8) == 0);
         a  = 2'($urandom);
         wd = 8'($urandom);
         if (w && a == 2'd2) wd[0] = ($urandom % 10) != 0;
         case (a)
            2'd0, 2'd1: tag = "R5";
            2'd2:       tag = "R7";
            default:    tag = "R11";
         endcase
         cyc(d, v, r, w, a, wd, tag);
      end
      idle();
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule